// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the host side of a two-wire programming link (a serial clock and a data line) and writes a stream of 14-bit words into a target's program memory. A single-cycle start pulse latches a start address and a mode. The words then arrive over a valid/ready input. The sequencer produces the serial clock, shifts out each command and data frame, and inserts the required gaps between frames. It also times the programming wait between the commands that begin and end each programming cycle.

There are two modes. In grouped mode, up to eight words are loaded into the target's latches, with an address-increment command between loads. One programming cycle then writes the whole group. In per-word mode, each loaded word gets its own programming cycle, started with the begin-only command. The target's address counter starts at zero after its reset and moves only on increment commands. For a nonzero start address, the host therefore sends that many increments before the first load. Raising the target into programming mode is handled elsewhere, and read-back is not part of this block.

Top module: `prog_link_host`

## Requirements
- R1: After reset `busy_o`, `done_o`, `word_ready_o`, `sck_o` and `sdo_o` are all 0.
- R2: A command frame is 6 serial clock pulses, least significant bit first. Default codes are: load word 6'b000010, begin cycle 6'b001000, begin cycle single 6'b011000, end cycle 6'b010111, increment address 6'b000110.
- R3: A data frame is 16 serial clock pulses. Bit 0 is a 0 start bit, bits 14..1 carry the word least significant bit first, and bit 15 is a 0 stop bit. Every data frame directly follows a load word command.
- R4: `sdo_o` changes only in a cycle in which `sck_o` rises, so the target can latch it on the falling edge.
- R5: Between the last falling clock edge of any frame and the first rising edge of the next frame, at least GAP_NS worth of system clocks pass (50 cycles at the defaults).
- R6: In grouped mode (`single_i`=0) each word is sent as load + data. Within a group, the words are separated by an increment. After the eighth word of a group, or after the word flagged last, the host sends begin cycle, then end cycle. An increment follows unless that word was the last.
- R7: In per-word mode (`single_i`=1) each word is sent as load + data, begin cycle single, end cycle. An increment follows unless that word was the last.
- R8: A start address of N sends exactly N increment commands before the first load.
- R9: At least PROG_NS worth of system clocks pass between the end of a begin command and the start of the following end command.
- R10: `busy_o` rises the cycle after start and stays high until the gap after the final end command has elapsed. `done_o` then pulses for exactly one cycle, with `busy_o` low.
- R11: A word is taken only on a cycle with `word_valid_i` and `word_ready_o` both high. `word_ready_o` is never high while the block is idle.
- R12: Each high and each low half of a serial clock pulse lasts HALF_NS worth of system clocks (5 cycles at the defaults), and `sck_o` is low outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| single_i | input | 1 | 1 selects per-word mode, sampled with start |
| start_addr_i | input | AW | Target start address, sampled with start |
| word_valid_i | input | 1 | Word stream valid |
| word_i | input | 14 | Word to program |
| word_last_i | input | 1 | Marks the final word of the image |
| word_ready_o | output | 1 | Block is ready to take a word |
| sck_o | output | 1 | Serial programming clock |
| sdo_o | output | 1 | Serial programming data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start_i` is pulsed only while `busy_o` is low. They also assume that the word stream holds `word_i` and `word_last_i` steady while it is valid and unaccepted, and that exactly one word per image carries the last flag. The bench drives the stream from a queue and advances it only after an observed accept. It marks only the final queued word as last and issues each start after the previous done pulse. A monitor decodes the serial line frame by frame on falling clock edges and measures gaps, half-periods and the programming wait in system cycles.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PREINC, ST_FETCH, ST_LDCMD, ST_LDDATA,
    ST_INC, ST_BEGIN, ST_WAIT, ST_END, ST_NEXTINC, ST_DONE
  } step_t;

  typedef enum logic [1:0] {PH_LAUNCH, PH_SHIFT, PH_GAP} phase_t;

  localparam int CMD_W = 6;
  localparam int WORD_W = 14;
  localparam int FRAME_W = WORD_W + 2;
endpackage

// File: rtl/pl_shifter.sv
module pl_shifter #(
  parameter int HALF_CYC = 5,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [4:0]    nbits_i,
  input  logic [FW-1:0] frame_i,
  output logic          sck_o,
  output logic          sdo_o,
  output logic          fin_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          act_q, act_n;
  logic          sck_q, sck_n;
  logic          sdo_q, sdo_n;
  logic          fin_q, fin_n;
  logic [FW-1:0] sr_q, sr_n;
  logic [4:0]    left_q, left_n;
  logic [HW-1:0] hc_q, hc_n;

  always_comb begin
    act_n = act_q; sck_n = sck_q; sdo_n = sdo_q; fin_n = 1'b0;
    sr_n = sr_q; left_n = left_q; hc_n = hc_q;
    if (!act_q) begin
      if (go_i) begin
        act_n  = 1'b1;
        sck_n  = 1'b1;
        sdo_n  = frame_i[0];
        sr_n   = frame_i >> 1;
        left_n = nbits_i - 5'd1;
        hc_n   = HW'(HALF_CYC - 1);
      end
    end else if (hc_q != '0) begin
      hc_n = hc_q - 1'b1;
    end else if (sck_q) begin
      sck_n = 1'b0;
      hc_n  = HW'(HALF_CYC - 1);
    end else if (left_q == '0) begin
      act_n = 1'b0;
      fin_n = 1'b1;
    end else begin
      sck_n  = 1'b1;
      sdo_n  = sr_q[0];
      sr_n   = sr_q >> 1;
      left_n = left_q - 5'd1;
      hc_n   = HW'(HALF_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; sck_q <= 1'b0; sdo_q <= 1'b0; fin_q <= 1'b0;
      sr_q <= '0; left_q <= '0; hc_q <= '0;
    end else begin
      act_q <= act_n; sck_q <= sck_n; sdo_q <= sdo_n; fin_q <= fin_n;
      sr_q <= sr_n; left_q <= left_n; hc_q <= hc_n;
    end
  end

  assign sck_o = sck_q;
  assign sdo_o = sdo_q;
  assign fin_o = fin_q;

  // data moves only together with a rising serial clock
  assert_sdo_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $rose(sck_q));
  // serial clock parked low whenever no frame is in flight
  assert_sck_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !$past(act_q)) |-> !sck_q);
endmodule

// File: rtl/pl_timer.sv
module pl_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] count_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i)             cnt_n = count_i;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expire_o = (cnt_q == TW'(1));

  // expiry is a single pulse per load
  assert_expire_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
endmodule

// File: rtl/prog_link_host.sv
module prog_link_host import pl_pkg::*; #(
  parameter longint CLK_KHZ = 50000,
  parameter longint HALF_NS = 100,
  parameter longint GAP_NS = 1000,
  parameter longint PROG_NS = 1000000,
  parameter int AW = 13,
  parameter int GROUP = 8,
  parameter logic [5:0] CODE_LOAD = 6'b000010,
  parameter logic [5:0] CODE_BEGIN = 6'b001000,
  parameter logic [5:0] CODE_BEGIN1 = 6'b011000,
  parameter logic [5:0] CODE_END = 6'b010111,
  parameter logic [5:0] CODE_INC = 6'b000110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          single_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          word_valid_i,
  input  logic [13:0]   word_i,
  input  logic          word_last_i,
  output logic          word_ready_o,
  output logic          sck_o,
  output logic          sdo_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int HALF_RAW = int'((CLK_KHZ * HALF_NS + 64'd999999) / 64'd1000000);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int GAP_CYC  = int'((CLK_KHZ * GAP_NS + 64'd999999) / 64'd1000000);
  localparam int PROG_CYC = int'((CLK_KHZ * PROG_NS + 64'd999999) / 64'd1000000);
  localparam int TMAX = (PROG_CYC > GAP_CYC) ? PROG_CYC : GAP_CYC;
  localparam int TW = $clog2(TMAX + 2);
  localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;

  step_t         st_q, st_n;
  phase_t        ph_q, ph_n;
  logic          single_q, single_n;
  logic          last_q, last_n;
  logic [13:0]   word_q, word_n;
  logic [AW-1:0] pre_q, pre_n;
  logic [GW-1:0] grp_q, grp_n;

  logic               sh_go, sh_fin, tmr_load, tmr_exp;
  logic [4:0]         sh_bits;
  logic [FRAME_W-1:0] sh_frame;
  logic [TW-1:0]      tmr_val;

  always_comb begin
    sh_bits  = 5'd6;
    sh_frame = '0;
    unique case (st_q)
      ST_LDCMD:  sh_frame[5:0] = CODE_LOAD;
      ST_LDDATA: begin sh_bits = 5'd16; sh_frame = {1'b0, word_q, 1'b0}; end
      ST_BEGIN:  sh_frame[5:0] = single_q ? CODE_BEGIN1 : CODE_BEGIN;
      ST_END:    sh_frame[5:0] = CODE_END;
      default:   sh_frame[5:0] = CODE_INC;
    endcase
  end

  always_comb begin
    st_n = st_q; ph_n = ph_q; single_n = single_q; last_n = last_q;
    word_n = word_q; pre_n = pre_q; grp_n = grp_q;
    sh_go = 1'b0; tmr_load = 1'b0; tmr_val = TW'(GAP_CYC);
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        single_n = single_i;
        pre_n    = start_addr_i;
        grp_n    = '0;
        last_n   = 1'b0;
        ph_n     = PH_LAUNCH;
        st_n     = (start_addr_i != '0) ? ST_PREINC : ST_FETCH;
      end
      ST_FETCH: if (word_valid_i) begin
        word_n = word_i;
        last_n = word_last_i;
        st_n   = ST_LDCMD;
      end
      ST_WAIT: begin
        if (ph_q == PH_LAUNCH) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(PROG_CYC);
          ph_n     = PH_GAP;
        end else if (tmr_exp) begin
          ph_n = PH_LAUNCH;
          st_n = ST_END;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: begin
        unique case (ph_q)
          PH_LAUNCH: begin sh_go = 1'b1; ph_n = PH_SHIFT; end
          PH_SHIFT: if (sh_fin) begin tmr_load = 1'b1; ph_n = PH_GAP; end
          default: if (tmr_exp) begin
            ph_n = PH_LAUNCH;
            unique case (st_q)
              ST_PREINC: begin
                pre_n = pre_q - 1'b1;
                st_n  = (pre_q == AW'(1)) ? ST_FETCH : ST_PREINC;
              end
              ST_LDCMD: st_n = ST_LDDATA;
              ST_LDDATA: begin
                if (single_q) st_n = ST_BEGIN;
                else if (last_q || grp_q == GW'(GROUP - 1)) begin
                  grp_n = '0;
                  st_n  = ST_BEGIN;
                end else begin
                  grp_n = grp_q + 1'b1;
                  st_n  = ST_INC;
                end
              end
              ST_BEGIN: st_n = ST_WAIT;
              ST_END:   st_n = last_q ? ST_DONE : ST_NEXTINC;
              default:  st_n = ST_FETCH;
            endcase
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= PH_LAUNCH; single_q <= 1'b0; last_q <= 1'b0;
      word_q <= '0; pre_q <= '0; grp_q <= '0;
    end else begin
      st_q <= st_n; ph_q <= ph_n; single_q <= single_n; last_q <= last_n;
      word_q <= word_n; pre_q <= pre_n; grp_q <= grp_n;
    end
  end

  pl_shifter #(.HALF_CYC(HALF_CYC), .FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go_i(sh_go), .nbits_i(sh_bits),
    .frame_i(sh_frame), .sck_o(sck_o), .sdo_o(sdo_o), .fin_o(sh_fin)
  );

  pl_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .count_i(tmr_val),
    .expire_o(tmr_exp)
  );

  assign word_ready_o = (st_q == ST_FETCH);
  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o = (st_q == ST_DONE);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o) && !busy_o);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_ready_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> busy_o);
  assert_no_frame_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) == ST_WAIT) |-> !sck_o);
endmodule

// File: tb/prog_link_host_test.sv
module prog_link_host_test;
  localparam int HALF = 5, GAP = 50, PROG = 200;
  localparam logic [5:0] C_LD = 6'b000010, C_BG = 6'b001000, C_B1 = 6'b011000,
                         C_EN = 6'b010111, C_IN = 6'b000110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, single = 1'b0;
  logic [12:0] saddr = '0;
  logic wvalid = 1'b0, wlast = 1'b0;
  logic [13:0] wdata = '0;
  logic wready, sck, sdo, busy, done;

  int cyc = 0, checks = 0, fails = 0;
  int mon_len[$], mon_val[$], mon_t0[$], mon_t1[$];
  int exp_len[$], exp_val[$];
  logic [13:0] src[$];
  int src_idx = 0, accepted = 0, half_err = 0;
  bit feeding = 0;

  prog_link_host #(.PROG_NS(4000)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .single_i(single),
    .start_addr_i(saddr), .word_valid_i(wvalid), .word_i(wdata),
    .word_last_i(wlast), .word_ready_o(wready), .sck_o(sck), .sdo_o(sdo),
    .busy_o(busy), .done_o(done)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // serial monitor, sampled mid-cycle
  logic p_sck = 1'b0;
  int nb = 0, acc = 0, t_rise = 0, t_fall = 0, t_first = 0;
  always @(negedge clk) begin
    if (sck && !p_sck) begin
      if (nb == 0) t_first = cyc;
      else if (cyc - t_fall != HALF) half_err++;
      t_rise = cyc;
    end
    if (!sck && p_sck) begin
      if (cyc - t_rise != HALF) half_err++;
      acc = acc | (int'(sdo) << nb);
      nb++;
      t_fall = cyc;
    end
    if (!sck && !p_sck && nb > 0 && cyc - t_fall > 3 * HALF) begin
      mon_len.push_back(nb); mon_val.push_back(acc);
      mon_t0.push_back(t_first); mon_t1.push_back(t_fall);
      nb = 0; acc = 0;
    end
    p_sck = sck;
  end

  // word source: advances only after an observed accept (R11)
  bit pend = 0;
  always @(negedge clk) begin
    if (pend) begin src_idx++; accepted++; end
    wvalid = feeding && (src_idx < src.size());
    wdata  = wvalid ? src[src_idx] : '0;
    wlast  = wvalid && (src_idx == src.size() - 1);
    pend   = wready && wvalid;
  end

  task automatic push_cmd(logic [5:0] c);
    exp_len.push_back(6); exp_val.push_back(int'(c));
  endtask

  task automatic build(bit sgl, int addr, int n);
    int grp = 0;
    for (int a = 0; a < addr; a++) push_cmd(C_IN);
    for (int k = 0; k < n; k++) begin
      bit lst = (k == n - 1);
      push_cmd(C_LD);
      exp_len.push_back(16); exp_val.push_back(int'(src[k]) << 1);
      if (sgl || lst || grp == 7) begin
        push_cmd(sgl ? C_B1 : C_BG);
        push_cmd(C_EN);
        if (!lst) push_cmd(C_IN);
        grp = 0;
      end else begin
        push_cmd(C_IN);
        grp++;
      end
    end
  endtask

  task automatic run(string tag, bit sgl, int addr, int n, int seed);
    int t_start, t_done = 0, dpulses = 0, busy_gap = 0, wd = 0;
    src.delete(); mon_len.delete(); mon_val.delete(); mon_t0.delete();
    mon_t1.delete(); exp_len.delete(); exp_val.delete();
    for (int k = 0; k < n; k++) src.push_back(14'((seed * 977 + k * 3181) ^ (k << 9)));
    src_idx = 0; accepted = 0; half_err = 0;
    build(sgl, addr, n);
    @(negedge clk);
    single = sgl; saddr = 13'(addr); start = 1'b1; feeding = 1;
    t_start = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10", {tag, " busy after start"}, busy, 1);
    while (t_done == 0) begin
      @(negedge clk);
      wd++;
      if (done) begin
        dpulses++; t_done = cyc;
        check(!busy, "R10", {tag, " busy low with done"}, busy, 0);
      end else if (!busy) busy_gap++;
      if (wd > 40000) begin
        check(0, "R10", {tag, " watchdog"}, wd, 0);
        t_done = cyc;
      end
    end
    @(negedge clk);
    check(!done && !busy, "R10", {tag, " done is one cycle"}, done, 0);
    check(busy_gap == 0, "R10", {tag, " busy held through run"}, busy_gap, 0);
    feeding = 0;
    check(accepted == n, "R11", {tag, " words accepted"}, accepted, n);
    check(mon_len.size() == exp_len.size(), "R6", {tag, " frame count"},
          mon_len.size(), exp_len.size());
    for (int i = 0; i < exp_len.size() && i < mon_len.size(); i++) begin
      string rq = (exp_len[i] == 16) ? "R3" : (i < addr) ? "R8" : sgl ? "R7" : "R6";
      check(mon_len[i] == exp_len[i], "R2", {tag, " frame length"}, mon_len[i], exp_len[i]);
      check(mon_val[i] == exp_val[i], rq, {tag, " frame value"}, mon_val[i], exp_val[i]);
      if (i > 0) begin
        check(mon_t0[i] - mon_t1[i-1] >= GAP, "R5", {tag, " inter-frame gap"},
              mon_t0[i] - mon_t1[i-1], GAP);
        if (exp_val[i] == int'(C_EN) && exp_len[i] == 6)
          check(mon_t0[i] - mon_t1[i-1] >= PROG, "R9", {tag, " programming wait"},
                mon_t0[i] - mon_t1[i-1], PROG);
      end
    end
    if (mon_t1.size() > 0)
      check(t_done - mon_t1[mon_t1.size()-1] >= GAP, "R10", {tag, " trailing gap"},
            t_done - mon_t1[mon_t1.size()-1], GAP);
    check(half_err == 0, "R12", {tag, " half periods"}, half_err, 0);
    check(dpulses == 1 && t_done > t_start, "R10", {tag, " done pulses"}, dpulses, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wready && !sck && !sdo, "R1", "outputs in reset",
          {busy, done, wready, sck, sdo}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wready && !sck && !sdo, "R1", "idle after reset",
          {busy, done, wready, sck, sdo}, 0);
  endtask

  task automatic t_idle_no_start;
    wvalid = 1'b1;
    repeat (20) @(negedge clk);
    check(!wready && !sck, "R11", "no take while idle", wready, 0);
  endtask

  initial begin
    t_reset();
    t_idle_no_start();
    run("grouped 8 @0", 0, 0, 8, 1);            // R6
    run("grouped 10 @2", 0, 2, 10, 2);          // R6 R8 partial group
    run("per-word 3 @0", 1, 0, 3, 3);           // R7
    run("per-word 1 @1", 1, 1, 1, 4);           // R7 R8
    run("grouped 1 @0", 0, 0, 1, 5);            // R6 single-word group, R4 via bench frames
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule